// File: doc/BRIEF.md
# Write Protection Unlock Sequencer

This block sits between the latched write path of a parallel byte-wide EEPROM and its page write engine. It watches every write transaction (address and data) and looks for fixed, ordered key sequences. A three-write key turns the write-protect mode on. The same key, when protection is already on, opens the current byte-load window for ordinary data. A six-write key turns protection off. For each write it decides in the same cycle whether the byte may reach the array (`permit`) or must be dropped as part of a key (`key_consumed`).

The protect flag stands in for non-volatile storage. It starts cleared at power-up. After that only a completed key changes it, and the block reset leaves it alone. Partial key progress and the open window live in ordinary registers. The block reset clears them, and so does the load-timeout pulse from the page engine, which marks the end of a byte-load window. Every key address and data value, and the length of each key, is a parameter.

Top module: `wp_unlock_seq`

## Requirements
- R1: While `protect_state` is 0, every write that is not a key write is permitted. `permit` is 1 in the cycle of the write and `key_consumed` is 0.
- R2: The default enable key is 0xAA written to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. When the third write completes the key, `protect_state` reads 1 from the next cycle on.
- R3: While `protect_state` is 1 and no window is open, a plain write gets `permit` = 0.
- R4: Every write that matches the next expected entry of a key gets `key_consumed` = 1 and `permit` = 0 in its own cycle.
- R5: The default disable key is 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. When it completes, `protect_state` reads 0 from the next cycle on.
- R6: After a completed enable key, whether protection was on or off, later writes in the same window are permitted as data. This holds even for writes that look like key entries. `protect_state` stays 1.
- R7: A `load_timeout` pulse closes the open window. After it, plain writes are blocked again while protected.
- R8: A write whose address or data differs from the expected key entry is treated as a plain write. All partial key progress is discarded, and `protect_state` does not change.
- R9: A `load_timeout` pulse discards partial key progress. A key write that arrives in the same cycle as `load_timeout` is still consumed, but it completes nothing and `protect_state` does not change.
- R10: `protect_state` is 0 at power-up, and asserting `rst_n` does not change it. Reset does clear partial key progress.
- R11: When `wr_valid` is 0, `permit` and `key_consumed` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Clears key progress and the window, but not the protect flag |
| wr_valid | input | 1 | One-cycle pulse marking a latched write |
| wr_addr | input | AW (15) | Address of the write |
| wr_data | input | DW (8) | Data of the write |
| load_timeout | input | 1 | Pulse marking the end of the byte-load window |
| permit | output | 1 | The current write may be programmed into the array |
| key_consumed | output | 1 | The current write is a key entry and must be discarded |
| protect_state | output | 1 | Write-protect mode is on |

## Verification
The closing of the load window and the arrival of a key write can happen in the same cycle. The bench provokes this by pulsing `load_timeout` together with the final entry of an enable key. It expects the write to be consumed, and it expects `protect_state` to stay unchanged on the following cycle. A plain write after that is checked as well: it must still be permitted, which shows that neither the flag nor an open window was left behind. A second overlap is covered too. A write that looks like a key entry, sent inside an open window, must be passed through as data.

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int EN_LEN = 3,
  parameter int DIS_LEN = 6,
  parameter logic [EN_LEN*AW-1:0]  EN_ADDR  = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [EN_LEN*DW-1:0]  EN_DATA  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [DIS_LEN*AW-1:0] DIS_ADDR = {15'h5555, 15'h2AAA, 15'h5555,
                                               15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [DIS_LEN*DW-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA,
                                               8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_timeout,
  output logic          permit,
  output logic          key_consumed,
  output logic          protect_state
);
  localparam int ENW = (EN_LEN > 1) ? $clog2(EN_LEN) : 1;
  localparam int DSW = (DIS_LEN > 1) ? $clog2(DIS_LEN) : 1;
  localparam logic [ENW-1:0] EN_LAST  = ENW'(EN_LEN - 1);
  localparam logic [DSW-1:0] DIS_LAST = DSW'(DIS_LEN - 1);

  logic [ENW-1:0] en_step;
  logic [DSW-1:0] dis_step;
  logic           open_q;
  logic           prot_q = 1'b0;

  logic live, en_hit, dis_hit, en_done, dis_done;

  // key matching is suspended while a window is open
  assign live     = wr_valid & ~open_q;
  assign en_hit   = live && (wr_addr == EN_ADDR[en_step*AW +: AW])
                         && (wr_data == EN_DATA[en_step*DW +: DW]);
  assign dis_hit  = live && (wr_addr == DIS_ADDR[dis_step*AW +: AW])
                         && (wr_data == DIS_DATA[dis_step*DW +: DW]);
  assign en_done  = en_hit  && (en_step  == EN_LAST);
  assign dis_done = dis_hit && (dis_step == DIS_LAST);

  assign key_consumed  = en_hit | dis_hit;
  assign permit        = wr_valid & ~key_consumed & (~prot_q | open_q);
  assign protect_state = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_step  <= '0;
      dis_step <= '0;
      open_q   <= 1'b0;
    end else if (load_timeout) begin
      en_step  <= '0;
      dis_step <= '0;
      open_q   <= 1'b0;
    end else if (live) begin
      en_step  <= (en_hit && !en_done) ? en_step + 1'b1 : '0;
      dis_step <= (dis_hit && !dis_done && !en_done) ? dis_step + 1'b1 : '0;
      open_q   <= en_done;
    end
  end

  // stands in for a non-volatile cell: only a completed key changes it
  always_ff @(posedge clk) begin
    if (rst_n && !load_timeout) begin
      if (en_done)       prot_q <= 1'b1;
      else if (dis_done) prot_q <= 1'b0;
    end
  end
endmodule

module wp_unlock_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic load_timeout,
  input logic permit,
  input logic key_consumed,
  input logic protect_state
);
  a_r4_key_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    key_consumed |-> !permit);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (!permit && !key_consumed));
  a_r1_clear_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !key_consumed && !protect_state) |-> permit);
  a_r2_rise_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_state) |-> $past(key_consumed && !load_timeout));
  a_r5_fall_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_state) |-> $past(key_consumed && !load_timeout));
  a_r9_timeout_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
    load_timeout |=> $stable(protect_state));
  a_r7_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_timeout) && wr_valid && protect_state && !key_consumed) |-> !permit);
endmodule

bind wp_unlock_seq wp_unlock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .load_timeout(load_timeout),
  .permit(permit), .key_consumed(key_consumed), .protect_state(protect_state)
);

// File: tb/wp_unlock_seq_test.sv
module wp_unlock_seq_test;
  localparam time CLK_P = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        load_timeout = 1'b0;
  logic        permit, key_consumed, protect_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wp_unlock_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_timeout(load_timeout), .permit(permit),
    .key_consumed(key_consumed), .protect_state(protect_state)
  );

  typedef struct packed {
    logic        v;
    logic        t;
    logic [14:0] a;
    logic [7:0]  d;
    logic        p;
    logic        k;
    logic        s;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 15'h0010, 8'h11, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 plain write, clear
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 enable done
    '{1'b1, 1'b0, 15'h0100, 8'h33, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 data with enable
    '{1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 idle + timeout
    '{1'b1, 1'b0, 15'h0100, 8'h44, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 R7 blocked
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
    '{1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
    '{1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 unlock
    '{1'b1, 1'b0, 15'h0200, 8'h55, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 data passes
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 key-like data in window
    '{1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 close window
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
    '{1'b1, 1'b0, 15'h2AAB, 8'h55, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 address mismatch
    '{1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 progress discarded
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 disable key
    '{1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd5},
    '{1'b1, 1'b0, 15'h5555, 8'h80, 1'b0, 1'b1, 1'b1, 4'd5},
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd5},
    '{1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd5},
    '{1'b1, 1'b0, 15'h5555, 8'h20, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 disable done
    '{1'b1, 1'b0, 15'h0300, 8'h66, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 timeout mid-key
    '{1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 progress gone
    '{1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 15'h2AAA, 8'h56, 1'b1, 1'b0, 1'b0, 4'd8}   // R8 data mismatch
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic t, input logic [14:0] a,
                      input logic [7:0] d, input logic ep, input logic ek,
                      input logic es, input string tag);
    @(negedge clk);
    wr_valid = v; load_timeout = t; wr_addr = a; wr_data = d;
    #1;
    chk(tag, "permit", permit, ep);
    chk(tag, "key_consumed", key_consumed, ek);
    @(posedge clk);
    #1;
    wr_valid = 1'b0; load_timeout = 1'b0;
    chk(tag, "protect_state", protect_state, es);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // power-up reset state: R10 R11
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "protect_state at power-up", protect_state, 1'b0);
    chk("R11", "permit in reset", permit, 1'b0);
    chk("R11", "key_consumed in reset", key_consumed, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      step(TBL[i].v, TBL[i].t, TBL[i].a, TBL[i].d, TBL[i].p, TBL[i].k, TBL[i].s,
           $sformatf("R%0d row%0d", TBL[i].r, i));

    // R9: final enable entry lands together with the timeout pulse
    step(1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b1, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, "R9 coincident");
    step(1'b1, 1'b0, 15'h0400, 8'h77, 1'b1, 1'b0, 1'b0, "R9 after");

    // R10: flag survives reset; reset drops partial progress
    step(1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R10");
    step(1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R10");
    step(1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b1, "R10");
    step(1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, "R10");
    step(1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, "R10");
    step(1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, "R10");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "protect_state through reset", protect_state, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, "R10 progress cleared");
    step(1'b1, 1'b0, 15'h0500, 8'h12, 1'b0, 1'b0, 1'b1, "R3 still protected");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule